// File: doc/BRIEF.md
# Dual-Issue Pair Legality Checker

This block checks one decoded dual-operation vector instruction. Such an instruction packs two independent ALU operations, X and Y, into a single issue slot. Each operation has a source-0 operand, which may be a vector register, a scalar register, an inline constant or a literal. It also has a source-1 vector register, an optional source-2 read and a destination vector register.

The block compares the two halves against the pairing rules: register-bank read ports, even/odd pairing, the scalar operand budget, the wave width and the use of data-parallel lane permutes. It reports each broken rule on its own bit. It also gives a single legal bit and a skip bit for 64-lane waves. Results are registered one cycle after `valid` and held while `valid` is low.

Operand kind encoding is 0 = vector register, 1 = scalar register, 2 = inline constant and 3 = literal. Opcode class encoding is 0 = plain, 1 = fused multiply-add with constant (FMAK), 2 = multiply-accumulate and 3 = dot-product-accumulate. The bank of a register index is its bits [1:0].

Top module: `dualop_pair_checker`

## Requirements
- R1: When `wave64` is 1 on a valid cycle, the next cycle shows `skip`=1, `viol[0]`=1 and `legal`=0. On a 32-lane wave `skip` is 0.
- R2: A valid cycle with `dpp`=1 sets `viol[1]`.
- R3: If either operation has `*_s1_vgpr`=0, meaning source 1 is not a vector register, `viol[2]` is set.
- R4: `viol[3]` is set when both source-0 operands are of kind 0 and their indices agree in bits [1:0]. A source 0 of any other kind never conflicts.
- R5: `viol[4]` is set when both source-1 operands are vector registers with equal bits [1:0]. An operation of class 1 takes no part in this check.
- R6: An operation reads source 2 when `*_s2_en`=1 or its class is nonzero. The parity bit it reads there is taken from a different field per class: class 1 uses bit 0 of source-1, classes 2 and 3 use bit 0 of the destination, and class 0 uses bit 0 of `*_s2_idx`. `viol[5]` is set when both operations read source 2 with equal parity.
- R7: `viol[6]` is set when bit 0 of `x_dst` equals bit 0 of `y_dst`.
- R8: `viol[7]` flags a scalar budget overrun. Two literals with different values count as two literals. Two literals with the same value count as one shared literal. A pair is within budget with no literal, or with one literal and at most one scalar register. Literal values of operations whose source 0 is not a literal are ignored.
- R9: `legal` is 1 exactly when the registered violation vector is all zero.
- R10: Outputs change only on the clock edge where `valid` is 1, and they hold their values while `valid` is 0.
- R11: A synchronous active-high `rst` clears `legal`, `skip` and `viol` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction fields are present this cycle |
| wave64 | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| dpp | input | 1 | The instruction requests a lane-permute modifier |
| x_class | input | 2 | Opcode class of X |
| x_s0_kind | input | 2 | Source-0 kind of X |
| x_s0_idx | input | IDX_W | Source-0 register index of X |
| x_s1_vgpr | input | 1 | Source 1 of X is a vector register |
| x_s1_idx | input | IDX_W | Source-1 register index of X |
| x_s2_en | input | 1 | X reads source 2 explicitly |
| x_s2_idx | input | IDX_W | Explicit source-2 index of X |
| x_dst | input | IDX_W | Destination index of X |
| x_lit | input | LIT_W | Literal value of X |
| y_class | input | 2 | Opcode class of Y |
| y_s0_kind | input | 2 | Source-0 kind of Y |
| y_s0_idx | input | IDX_W | Source-0 register index of Y |
| y_s1_vgpr | input | 1 | Source 1 of Y is a vector register |
| y_s1_idx | input | IDX_W | Source-1 register index of Y |
| y_s2_en | input | 1 | Y reads source 2 explicitly |
| y_s2_idx | input | IDX_W | Explicit source-2 index of Y |
| y_dst | input | IDX_W | Destination index of Y |
| y_lit | input | LIT_W | Literal value of Y |
| legal | output | 1 | Registered: pair obeys every rule |
| skip | output | 1 | Registered: instruction is dropped for a 64-lane wave |
| viol | output | 8 | Registered violation bits, ordered as R1..R8 map to bits 0..7 |

## Verification
The hardest case to reach is source-2 parity. The parity bit comes from a different field for each opcode class, and the FMAK class also leaves the source-1 bank check. The stimulus table therefore holds pairs that give a bank clash on source 1 together with FMAK, so only the parity bit may react. It also mixes accumulate classes whose destination parity decides the source-2 clash, and sets explicit source-2 indices on plain operations. Literal sharing is covered as well: equal and unequal literals are presented, and unequal literal values are placed on operands that are not literals, to show they are ignored.

// File: rtl/dualop_pair_checker.sv
module dualop_pair_checker #(
  parameter int IDX_W = 8,
  parameter int LIT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             wave64,
  input  logic             dpp,
  input  logic [1:0]       x_class,
  input  logic [1:0]       x_s0_kind,
  input  logic [IDX_W-1:0] x_s0_idx,
  input  logic             x_s1_vgpr,
  input  logic [IDX_W-1:0] x_s1_idx,
  input  logic             x_s2_en,
  input  logic [IDX_W-1:0] x_s2_idx,
  input  logic [IDX_W-1:0] x_dst,
  input  logic [LIT_W-1:0] x_lit,
  input  logic [1:0]       y_class,
  input  logic [1:0]       y_s0_kind,
  input  logic [IDX_W-1:0] y_s0_idx,
  input  logic             y_s1_vgpr,
  input  logic [IDX_W-1:0] y_s1_idx,
  input  logic             y_s2_en,
  input  logic [IDX_W-1:0] y_s2_idx,
  input  logic [IDX_W-1:0] y_dst,
  input  logic [LIT_W-1:0] y_lit,
  output logic             legal,
  output logic             skip,
  output logic [7:0]       viol
);
  localparam int NRULE = 8;
  localparam int BANK_W = 2;
  localparam logic [1:0] K_VGPR = 2'd0, K_SGPR = 2'd1, K_LIT = 2'd3;
  localparam logic [1:0] C_PLAIN = 2'd0, C_FMAK = 2'd1, C_MAC = 2'd2, C_DOT = 2'd3;

  logic x_fmak, y_fmak, x_s2use, y_s2use, x_s2par, y_s2par;
  logic x_islit, y_islit;
  logic [1:0] n_sgpr, n_lit;
  logic [NRULE-1:0] nxt;
  logic unused_hi;

  assign x_fmak  = x_class == C_FMAK;
  assign y_fmak  = y_class == C_FMAK;
  assign x_s2use = x_s2_en | (x_class != C_PLAIN);
  assign y_s2use = y_s2_en | (y_class != C_PLAIN);
  assign x_s2par = x_fmak ? x_s1_idx[0] :
                   (x_class == C_MAC || x_class == C_DOT) ? x_dst[0] : x_s2_idx[0];
  assign y_s2par = y_fmak ? y_s1_idx[0] :
                   (y_class == C_MAC || y_class == C_DOT) ? y_dst[0] : y_s2_idx[0];

  assign x_islit = x_s0_kind == K_LIT;
  assign y_islit = y_s0_kind == K_LIT;
  assign n_sgpr  = {1'b0, x_s0_kind == K_SGPR} + {1'b0, y_s0_kind == K_SGPR};
  assign n_lit   = (x_islit && y_islit && x_lit == y_lit) ? 2'd1 :
                   {1'b0, x_islit} + {1'b0, y_islit};

  assign nxt[0] = wave64;
  assign nxt[1] = dpp;
  assign nxt[2] = ~x_s1_vgpr | ~y_s1_vgpr;
  assign nxt[3] = (x_s0_kind == K_VGPR) && (y_s0_kind == K_VGPR) &&
                  (x_s0_idx[BANK_W-1:0] == y_s0_idx[BANK_W-1:0]);
  assign nxt[4] = x_s1_vgpr && y_s1_vgpr && !x_fmak && !y_fmak &&
                  (x_s1_idx[BANK_W-1:0] == y_s1_idx[BANK_W-1:0]);
  assign nxt[5] = x_s2use && y_s2use && (x_s2par == y_s2par);
  assign nxt[6] = x_dst[0] == y_dst[0];
  assign nxt[7] = !((n_lit == 2'd0) || (n_lit == 2'd1 && n_sgpr <= 2'd1));

  assign unused_hi = ^{x_s0_idx[IDX_W-1:BANK_W], y_s0_idx[IDX_W-1:BANK_W],
                       x_s1_idx[IDX_W-1:BANK_W], y_s1_idx[IDX_W-1:BANK_W],
                       x_s2_idx[IDX_W-1:1], y_s2_idx[IDX_W-1:1],
                       x_dst[IDX_W-1:1], y_dst[IDX_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      legal <= 1'b0;
      skip  <= 1'b0;
      viol  <= '0;
    end else if (valid) begin
      legal <= ~|nxt;
      skip  <= wave64;
      viol  <= nxt;
    end
  end
endmodule

module dualop_pair_checker_sva #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic             wave64,
  input logic             dpp,
  input logic [IDX_W-1:0] x_dst,
  input logic [IDX_W-1:0] y_dst,
  input logic             legal,
  input logic             skip,
  input logic [7:0]       viol
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!legal && !skip && viol == 8'd0));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(legal) && $stable(skip) && $stable(viol)));
  assert_skip_follow_R1: assert property (@(posedge clk) disable iff (rst)
    valid |=> (skip == $past(wave64)));
  assert_wide_illegal_R1: assert property (@(posedge clk) disable iff (rst)
    (valid && wave64) |=> (viol[0] && !legal));
  assert_dpp_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && dpp) |=> (viol[1] && !legal));
  assert_dst_parity_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && (x_dst[0] == y_dst[0])) |=> viol[6]);
  assert_legal_clean_R9: assert property (@(posedge clk) disable iff (rst)
    legal |-> (viol == 8'd0));
endmodule

bind dualop_pair_checker dualop_pair_checker_sva #(.IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst(rst), .valid(valid), .wave64(wave64), .dpp(dpp),
  .x_dst(x_dst), .y_dst(y_dst), .legal(legal), .skip(skip), .viol(viol)
);

// File: tb/dualop_pair_checker_tb.sv
module dualop_pair_checker_tb;
  typedef struct packed {
    logic w64; logic dpp;
    logic [1:0] xc; logic [1:0] xk; logic [7:0] xi0; logic xv1; logic [7:0] xi1;
    logic xe2; logic [7:0] xi2; logic [7:0] xd; logic [31:0] xl;
    logic [1:0] yc; logic [1:0] yk; logic [7:0] yi0; logic yv1; logic [7:0] yi1;
    logic ye2; logic [7:0] yi2; logic [7:0] yd; logic [31:0] yl;
    logic [7:0] ev;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    // R9 clean baseline
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h00},
    // R1 wave64
    '{1'b1,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h01},
    // R2 dpp
    '{1'b0,1'b1, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h02},
    // R3 src1 of Y not a vector register
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b0,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h04},
    // R4 src0 bank clash 0 vs 4
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd4,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h08},
    // R4 same bank but Y src0 scalar
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd1,8'd4,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h00},
    // R5 src1 bank clash 0 vs 8
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd8,1'b0,8'd0,8'd1,32'd0, 8'h10},
    // R5 clash excused by FMAK on Y
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd1,2'd0,8'd1,1'b1,8'd8,1'b0,8'd0,8'd1,32'd0, 8'h00},
    // R6 explicit src2 both even
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b1,8'd2,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b1,8'd6,8'd1,32'd0, 8'h20},
    // R6 MAC dst even vs FMAK src1 odd
    '{1'b0,1'b0, 2'd2,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd1,2'd0,8'd1,1'b1,8'd5,1'b0,8'd0,8'd1,32'd0, 8'h00},
    // R6 MAC dst even vs FMAK src1 even
    '{1'b0,1'b0, 2'd2,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd1,2'd0,8'd1,1'b1,8'd4,1'b0,8'd0,8'd1,32'd0, 8'h20},
    // R6 DOT dst even vs explicit src2 even
    '{1'b0,1'b0, 2'd3,2'd0,8'd0,1'b1,8'd0,1'b0,8'd7,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b1,8'd2,8'd1,32'd0, 8'h20},
    // R7 both destinations odd
    '{1'b0,1'b0, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd3,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd1,32'd0, 8'h40},
    // R8 shared literal
    '{1'b0,1'b0, 2'd0,2'd3,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd5, 2'd0,2'd3,8'd0,1'b1,8'd1,1'b0,8'd0,8'd1,32'd5, 8'h00},
    // R8 two different literals
    '{1'b0,1'b0, 2'd0,2'd3,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd5, 2'd0,2'd3,8'd0,1'b1,8'd1,1'b0,8'd0,8'd1,32'd6, 8'h80},
    // R8 one scalar plus one literal
    '{1'b0,1'b0, 2'd0,2'd1,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd9, 2'd0,2'd3,8'd0,1'b1,8'd1,1'b0,8'd0,8'd1,32'd6, 8'h00},
    // R8 differing literal values on non-literal operands ignored
    '{1'b0,1'b0, 2'd0,2'd2,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd1, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd1,32'd2, 8'h00},
    // R1 R2 R7 together
    '{1'b1,1'b1, 2'd0,2'd0,8'd0,1'b1,8'd0,1'b0,8'd0,8'd0,32'd0, 2'd0,2'd0,8'd1,1'b1,8'd1,1'b0,8'd0,8'd2,32'd0, 8'h43}
  };

  logic clk = 1'b0, rst = 1'b1, valid = 1'b0, wave64 = 1'b0, dpp = 1'b0;
  logic [1:0] x_class = '0, x_s0_kind = '0, y_class = '0, y_s0_kind = '0;
  logic [7:0] x_s0_idx = '0, x_s1_idx = '0, x_s2_idx = '0, x_dst = '0;
  logic [7:0] y_s0_idx = '0, y_s1_idx = '0, y_s2_idx = '0, y_dst = '0;
  logic x_s1_vgpr = 1'b1, y_s1_vgpr = 1'b1, x_s2_en = 1'b0, y_s2_en = 1'b0;
  logic [31:0] x_lit = '0, y_lit = '0;
  logic legal, skip;
  logic [7:0] viol;
  int total = 0, bad = 0;
  logic [7:0] keep_v;
  logic keep_l, keep_s;

  always #4 clk = ~clk;

  dualop_pair_checker u_dut (
    .clk(clk), .rst(rst), .valid(valid), .wave64(wave64), .dpp(dpp),
    .x_class(x_class), .x_s0_kind(x_s0_kind), .x_s0_idx(x_s0_idx), .x_s1_vgpr(x_s1_vgpr),
    .x_s1_idx(x_s1_idx), .x_s2_en(x_s2_en), .x_s2_idx(x_s2_idx), .x_dst(x_dst), .x_lit(x_lit),
    .y_class(y_class), .y_s0_kind(y_s0_kind), .y_s0_idx(y_s0_idx), .y_s1_vgpr(y_s1_vgpr),
    .y_s1_idx(y_s1_idx), .y_s2_en(y_s2_en), .y_s2_idx(y_s2_idx), .y_dst(y_dst), .y_lit(y_lit),
    .legal(legal), .skip(skip), .viol(viol)
  );

  function automatic string tag_of(logic [7:0] e);
    if (e == 8'd0) return "R9";
    for (int b = 0; b < 8; b++) if (e[b]) return $sformatf("R%0d", b + 1);
    return "R9";
  endfunction

  task automatic check(string req, logic [7:0] ev, logic el, logic es);
    total++;
    if (viol !== ev || legal !== el || skip !== es) begin
      bad++;
      $display("FAIL %s: viol=%h legal=%b skip=%b expected viol=%h legal=%b skip=%b",
               req, viol, legal, skip, ev, el, es);
    end
  endtask

  task automatic drive(vec_t v);
    wave64 = v.w64; dpp = v.dpp;
    x_class = v.xc; x_s0_kind = v.xk; x_s0_idx = v.xi0; x_s1_vgpr = v.xv1; x_s1_idx = v.xi1;
    x_s2_en = v.xe2; x_s2_idx = v.xi2; x_dst = v.xd; x_lit = v.xl;
    y_class = v.yc; y_s0_kind = v.yk; y_s0_idx = v.yi0; y_s1_vgpr = v.yv1; y_s1_idx = v.yi1;
    y_s2_en = v.ye2; y_s2_idx = v.yi2; y_dst = v.yd; y_lit = v.yl;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      check(tag_of(TBL[i].ev), TBL[i].ev, TBL[i].ev == 8'd0, TBL[i].ev[0]);
    end
    // R10 hold: present a clean pair without valid, outputs keep the 8'h43 result
    keep_v = viol; keep_l = legal; keep_s = skip;
    drive(TBL[0]);
    repeat (2) @(negedge clk);
    check("R10 hold", keep_v, keep_l, keep_s);
    // R10 update lands one edge after valid
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R10 update", 8'h00, 1'b1, 1'b0);
    // R11 reset after an illegal result
    drive(TBL[1]);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R1 wave64 again", 8'h01, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R11 clear", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule